// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block drives bursts out of an on-chip 16-bit buffer memory toward a synchronous host port. The host writes a mode word while the sequencer is idle: an initial latency, a burst length code, a burst mode and a clock speed grade. It then presents a start word address with a one-cycle start strobe. The sequencer counts the programmed latency, raises a ready strobe on every cycle that carries a valid word, and steps the buffer address once per clock. Depending on the mode, the address either wraps inside an aligned window or simply counts upward across sector and page boundaries.

Three burst modes exist. A linear wrap mode covers 4, 8, 16 and 32 words. A continuous mode streams 1024 words inside its aligned 1024-word window. A block mode never wraps and runs 4, 8, 16, 32 or 1024 words. A mode word that is not legal for the declared speed grade raises a configuration error, and start requests are then refused. Dropping chip enable ends a burst at once.

The buffer model is read-only. Each word it returns is its own word address XOR a seed, so the host side can tell which address was read.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the sequencer is idle with `rdy` low and `cfgErr` low. The mode word resets to latency 4, length code 0, wrap mode and speed grade 0, so a burst started without any mode write gives 4 words after 4 cycles.
- R2: The first word is valid exactly L clock edges after the edge that captures `startReq`, where L is the programmed latency (3 to 7). `rdy` is high on exactly the burst-length consecutive cycles that carry words and low at all other times.
- R3: In wrap mode (`cfgMode`=0), beat i reads address `(S & ~(N-1)) | ((S+i) & (N-1))`, where S is the start address and N is the burst length. Every word on `dout` equals its address XOR 16'h5A3C.
- R4: In continuous mode (`cfgMode`=1), 1024 words are read, wrapping inside the aligned 1024-word window, and the length code is ignored.
- R5: In block mode (`cfgMode`=2), beat i reads address S+i modulo 2^16, with no wrap. This lets a burst cross 256-word sector and 1024-word page boundaries.
- R6: Length code 0, 1, 2, 3 selects 4, 8, 16 or 32 words. Length code 4 selects 1024 words and is legal only in block mode.
- R7: `cfgErr` is high when the latency is below the minimum for the speed grade. The minimum is 3 for grade 0, 4 for grade 1, and 6 for grades 2 and 3. `cfgErr` is also high for mode 3, for a length code above 3 in wrap mode, and for a length code above 4 in block mode. While `cfgErr` is high a start request is ignored.
- R8: While `chipEn` is low, `rdy` is low in the same cycle. The sequencer returns to idle and does not resume the aborted burst.
- R9: Mode writes and start requests that arrive while a burst is active (waiting or streaming) have no effect on that burst or on the stored mode word.
- R10: A start request with `chipEn` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEn | input | 1 | Chip enable; low aborts any burst |
| startReq | input | 1 | Start strobe, captures `startAddr` |
| startAddr | input | 16 | Start word address |
| cfgWr | input | 1 | Mode word write strobe (idle only) |
| cfgLat | input | 3 | Initial latency in clocks |
| cfgLen | input | 3 | Burst length code |
| cfgMode | input | 2 | 0 wrap, 1 continuous, 2 block |
| cfgSpeed | input | 2 | Clock speed grade |
| cfgErr | output | 1 | Stored mode word is illegal |
| rdy | output | 1 | Data valid strobe |
| dout | output | 16 | Burst data word |

## Verification
A wrong latency count shows up as `rdy` rising one or more cycles early or late on the very first beat. A faulty beat counter shows up as a burst that is one word short or one word long. A wrong window mask in the address generator gives a word that does not match the expected address on the first beat past a window or page boundary, because each word carries its own address. A mode register that is not frozen while busy, or a chip-enable gate that is wrong, shows up within one cycle of the disturbing input.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP  = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_BLOCK = 2'd2,
    MODE_BAD   = 2'd3
  } mode_e;

  typedef struct packed {
    logic [2:0] lat;
    logic [2:0] lenCode;
    mode_e      mode;
    logic [1:0] speed;
  } cfg_t;

  typedef struct packed {
    logic load;
    logic step;
  } dpCtl_t;

  function automatic logic [3:0] lenLog(input cfg_t c);
    if (c.mode == MODE_CONT || c.lenCode == 3'd4) return 4'd10;
    return 4'd2 + {2'b00, c.lenCode[1:0]};
  endfunction

  function automatic logic cfgIllegal(input cfg_t c);
    logic latBad;
    logic lenBad;
    case (c.speed)
      2'd0:    latBad = c.lat < 3'd3;
      2'd1:    latBad = c.lat < 3'd4;
      default: latBad = c.lat < 3'd6;
    endcase
    case (c.mode)
      MODE_WRAP:  lenBad = c.lenCode > 3'd3;
      MODE_CONT:  lenBad = 1'b0;
      MODE_BLOCK: lenBad = c.lenCode > 3'd4;
      default:    lenBad = 1'b1;
    endcase
    return latBad | lenBad;
  endfunction
endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int MAX_LOG = 10,
  localparam int CNT_W = MAX_LOG + 1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   chipEn,
  input  logic   startReq,
  input  logic   cfgWr,
  input  cfg_t   cfgIn,
  output cfg_t   cfgCur,
  output logic   cfgErr,
  output logic   busy,
  output logic   rdyQ,
  output logic   wrapEn,
  output logic [3:0] winLog,
  output dpCtl_t ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BURST} state_e;

  state_e     state;
  cfg_t       cfgQ;
  logic [2:0] latCnt;
  logic [CNT_W-1:0] beatCnt;
  logic       startGo;
  logic       fire;
  logic [3:0] curLog;
  logic [CNT_W-1:0] beatLoad;

  assign cfgErr   = cfgIllegal(cfgQ);
  assign curLog   = lenLog(cfgQ);
  assign beatLoad = (CNT_W'(1) << curLog) - CNT_W'(1);
  assign startGo  = (state == ST_IDLE) && startReq && chipEn && !cfgErr;
  assign fire     = (state == ST_BURST) && chipEn;
  assign busy     = (state != ST_IDLE);
  assign ctl      = '{load: startGo, step: fire};
  assign wrapEn   = (cfgQ.mode != MODE_BLOCK);
  assign winLog   = curLog;
  assign cfgCur   = cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cfgQ    <= '{lat: 3'd4, lenCode: 3'd0, mode: MODE_WRAP, speed: 2'd0};
      latCnt  <= '0;
      beatCnt <= '0;
      rdyQ    <= 1'b0;
    end else begin
      rdyQ <= fire;
      if (cfgWr && state == ST_IDLE && !startGo) cfgQ <= cfgIn;
      case (state)
        ST_IDLE: begin
          if (startGo) begin
            state   <= ST_WAIT;
            latCnt  <= cfgQ.lat - 3'd1;
            beatCnt <= beatLoad;
          end
        end
        ST_WAIT: begin
          if (!chipEn)              state  <= ST_IDLE;
          else if (latCnt == 3'd1)  state  <= ST_BURST;
          else                      latCnt <= latCnt - 3'd1;
        end
        ST_BURST: begin
          if (!chipEn || beatCnt == '0) state   <= ST_IDLE;
          else                          beatCnt <= beatCnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/brs_addrgen.sv
module brs_addrgen
  import brs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              wrapEn,
  input  logic [3:0]        winLog,
  output logic [ADDR_W-1:0] curAddr
);
  logic [ADDR_W-1:0] winMask;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] nextAddr;

  assign winMask  = (ADDR_W'(1) << winLog) - ADDR_W'(1);
  assign incAddr  = curAddr + ADDR_W'(1);
  assign nextAddr = wrapEn ? ((curAddr & ~winMask) | (incAddr & winMask)) : incAddr;

  always_ff @(posedge clk) begin
    if (!rstN)         curAddr <= '0;
    else if (ctl.load) curAddr <= startAddr;
    else if (ctl.step) curAddr <= nextAddr;
  end
endmodule

// File: rtl/brs_bufram.sv
module brs_bufram #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData
);
  // Read-only model: each word holds its own address XOR a seed.
  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= DATA_W'(addr) ^ SEED;
  end
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int MAX_LOG = 10,
  parameter logic [DATA_W-1:0] SEED = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              cfgWr,
  input  logic [2:0]        cfgLat,
  input  logic [2:0]        cfgLen,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgSpeed,
  output logic              cfgErr,
  output logic              rdy,
  output logic [DATA_W-1:0] dout
);
  cfg_t              cfgIn;
  cfg_t              cfgCur;
  dpCtl_t            ctl;
  logic              busy;
  logic              rdyQ;
  logic              wrapEn;
  logic [3:0]        winLog;
  logic [ADDR_W-1:0] curAddr;

  assign cfgIn = '{lat: cfgLat, lenCode: cfgLen, mode: mode_e'(cfgMode), speed: cfgSpeed};
  assign rdy   = rdyQ & chipEn;

  brs_ctrl #(.MAX_LOG(MAX_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .startReq(startReq),
    .cfgWr(cfgWr), .cfgIn(cfgIn), .cfgCur(cfgCur), .cfgErr(cfgErr),
    .busy(busy), .rdyQ(rdyQ), .wrapEn(wrapEn), .winLog(winLog), .ctl(ctl)
  );

  brs_addrgen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .wrapEn(wrapEn), .winLog(winLog), .curAddr(curAddr)
  );

  brs_bufram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) u_ram (
    .clk(clk), .rstN(rstN), .rdEn(ctl.step), .addr(curAddr), .rdData(dout)
  );
endmodule

// File: rtl/brs_chk.sv
module brs_chk
  import brs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED = 16'h5A3C
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEn,
  input logic              rdy,
  input logic [DATA_W-1:0] dout,
  input logic              cfgErr,
  input logic              busy,
  input cfg_t              cfgCur
);
  p_abort_rdy_r8: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |-> !rdy);

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> !busy);

  p_rdy_after_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdy |-> $past(busy));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cfgCur));

  p_err_no_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !busy) |=> !busy);

  p_block_linear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdy && $past(rdy) && cfgCur.mode == MODE_BLOCK)
      |-> ((dout ^ SEED) == (($past(dout) ^ SEED) + DATA_W'(1))));

  p_wrap_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdy && $past(rdy) && cfgCur.mode == MODE_WRAP)
      |-> (((dout ^ SEED) >> 5) == (($past(dout) ^ SEED) >> 5)));
endmodule

bind burst_read_seq brs_chk #(.DATA_W(DATA_W), .SEED(SEED)) u_chk (
  .clk(clk), .rstN(rstN), .chipEn(chipEn), .rdy(rdy), .dout(dout),
  .cfgErr(cfgErr), .busy(busy), .cfgCur(cfgCur)
);

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;
  localparam logic [15:0] SEED = 16'h5A3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 1'b1;
  logic startReq = 1'b0;
  logic [15:0] startAddr = '0;
  logic cfgWr = 1'b0;
  logic [2:0] cfgLat = 3'd4;
  logic [2:0] cfgLen = 3'd0;
  logic [1:0] cfgMode = 2'd0;
  logic [1:0] cfgSpeed = 2'd0;
  logic cfgErr;
  logic rdy;
  logic [15:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_read_seq i_burst_read_seq (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .startReq(startReq),
    .startAddr(startAddr), .cfgWr(cfgWr), .cfgLat(cfgLat), .cfgLen(cfgLen),
    .cfgMode(cfgMode), .cfgSpeed(cfgSpeed), .cfgErr(cfgErr), .rdy(rdy), .dout(dout)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input int lat, input int lc, input int md, input int sp);
    @(negedge clk);
    cfgWr = 1'b1; cfgLat = 3'(lat); cfgLen = 3'(lc); cfgMode = 2'(md); cfgSpeed = 2'(sp);
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  function automatic logic [15:0] expAddr(input logic [15:0] st, input int len,
                                          input int md, input int i);
    logic [15:0] m;
    logic [15:0] s;
    s = st + 16'(i);
    if (md == 2) return s;
    m = (md == 1) ? 16'd1023 : 16'(len - 1);
    return (st & ~m) | (s & m);
  endfunction

  // One burst, checked beat by beat; one reported check per burst.
  task automatic runBurst(input logic [15:0] st, input int lat, input int len,
                          input int md, input string req, input bit disturb);
    int bad = 0;
    int actV = 0;
    int expV = 0;
    @(negedge clk);
    startReq = 1'b1; startAddr = st;
    @(negedge clk);
    startReq = 1'b0;
    for (int k = 1; k <= lat + len + 1; k++) begin
      bit expRdy;
      logic [15:0] ed;
      @(negedge clk);
      expRdy = (k >= lat) && (k < lat + len);
      ed = expAddr(st, len, md, k - lat) ^ SEED;
      if (rdy !== expRdy || (expRdy && dout !== ed)) begin
        if (bad == 0) begin
          actV = {15'(dout), rdy};
          expV = {15'(ed), expRdy};
        end
        bad++;
      end
      if (disturb && k == 2) begin
        cfgWr = 1'b1; cfgLat = 3'd3; cfgLen = 3'd3; cfgMode = 2'd2;
        startReq = 1'b1; startAddr = 16'h7777;
      end else begin
        cfgWr = 1'b0; startReq = 1'b0;
      end
    end
    check(bad == 0, req, $sformatf("burst st=%0h lat=%0d len=%0d mode=%0d {data,rdy}",
          st, lat, len, md), actV, expV);
  endtask

  function automatic int lenOf(input int lc);
    return (lc <= 3) ? (4 << lc) : 1024;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state and default mode word
    check(rdy == 1'b0, "R1", "rdy after reset", int'(rdy), 0);
    check(cfgErr == 1'b0, "R1", "cfgErr after reset", int'(cfgErr), 0);
    runBurst(16'h0013, 4, 4, 0, "R1", 1'b0);

    // R2, R3, R6: wrap mode sweep over all latencies and lengths
    for (int lat = 3; lat <= 7; lat++)
      for (int lc = 0; lc <= 3; lc++) begin
        writeCfg(lat, lc, 0, 0);
        runBurst(16'h4C40, lat, lenOf(lc), 0, "R3", 1'b0);
        runBurst(16'(16'h4C40 + 11 + lat), lat, lenOf(lc), 0, "R2", 1'b0);
      end

    // R4: continuous mode; length code ignored
    for (int lat = 3; lat <= 7; lat++) begin
      writeCfg(lat, 7, 1, 0);
      runBurst(16'(16'h23F0 + lat * 97), lat, 1024, 1, "R4", 1'b0);
    end
    runBurst(16'h2400, 7, 1024, 1, "R4", 1'b0);

    // R5, R6: block mode, crossing page boundaries, no wrap
    for (int lat = 3; lat <= 7; lat++)
      for (int lc = 0; lc <= 4; lc++) begin
        writeCfg(lat, lc, 2, 0);
        runBurst(16'(16'h03FE - lat), lat, lenOf(lc), 2, "R5", 1'b0);
        runBurst(16'h0800, lat, lenOf(lc), 2, "R6", 1'b0);
      end
    writeCfg(3, 2, 2, 0);
    runBurst(16'hFFF8, 3, 16, 2, "R5", 1'b0);

    // R7: latency legality against speed grade
    for (int sp = 0; sp <= 3; sp++)
      for (int lat = 0; lat <= 7; lat++) begin
        bit expErr;
        writeCfg(lat, 0, 0, sp);
        expErr = (sp == 0) ? (lat < 3) : (sp == 1) ? (lat < 4) : (lat < 6);
        check(cfgErr == expErr, "R7", $sformatf("cfgErr sp=%0d lat=%0d", sp, lat),
              int'(cfgErr), int'(expErr));
      end
    writeCfg(6, 4, 0, 2);
    check(cfgErr == 1'b1, "R7", "wrap with 1024 code", int'(cfgErr), 1);
    writeCfg(6, 5, 2, 2);
    check(cfgErr == 1'b1, "R7", "block with code 5", int'(cfgErr), 1);
    writeCfg(6, 7, 1, 2);
    check(cfgErr == 1'b0, "R7", "continuous ignores code", int'(cfgErr), 0);
    writeCfg(4, 0, 3, 0);
    check(cfgErr == 1'b1, "R7", "mode 3", int'(cfgErr), 1);
    begin
      int seen = 0;
      @(negedge clk); startReq = 1'b1; startAddr = 16'h0040;
      @(negedge clk); startReq = 1'b0;
      for (int k = 0; k < 12; k++) begin @(negedge clk); seen += int'(rdy); end
      check(seen == 0, "R7", "rdy cycles after refused start", seen, 0);
    end

    // R8: chip enable abort
    writeCfg(4, 4, 2, 0);
    @(negedge clk); startReq = 1'b1; startAddr = 16'h0100;
    @(negedge clk); startReq = 1'b0;
    for (int k = 1; k <= 4 + 5; k++) @(negedge clk);
    check(rdy == 1'b1 && dout == (16'h0105 ^ SEED), "R8", "beat 5 before abort",
          int'(dout), int'(16'h0105 ^ SEED));
    chipEn = 1'b0;
    #1;
    check(rdy == 1'b0, "R8", "rdy same cycle as chipEn low", int'(rdy), 0);
    @(negedge clk); chipEn = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin @(negedge clk); seen += int'(rdy); end
      check(seen == 0, "R8", "no resume after abort", seen, 0);
    end
    runBurst(16'h0200, 4, 1024, 2, "R8", 1'b0);

    // R9: mode write and start while busy ignored
    writeCfg(5, 1, 0, 0);
    runBurst(16'h1235, 5, 8, 0, "R9", 1'b1);
    runBurst(16'h1235, 5, 8, 0, "R9", 1'b0);

    // R10: start with chip enable low
    @(negedge clk); chipEn = 1'b0; startReq = 1'b1; startAddr = 16'h0300;
    @(negedge clk); chipEn = 1'b1; startReq = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 12; k++) begin @(negedge clk); seen += int'(rdy); end
      check(seen == 0, "R10", "rdy cycles after start with chipEn low", seen, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule